// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside the fetch stage and answers one question each cycle: is the instruction at the current fetch address a branch seen before and expected to jump, and if so, where to? The fetch address is compared in full against every stored entry. On a hit whose 2-bit confidence counter has its upper bit set, the block steers fetch to the stored destination. In every other case fetch moves on to the next sequential word, the address plus 4. The lookup path is purely combinational from the stored state.

A second port carries the outcome of a branch from the execute stage. It reports the real direction and destination, together with the direction and destination that fetch used. The block raises a mispredict flag and a restart address, which the pipeline uses to squash the wrong-path instruction and refetch. In the same cycle it updates the table. A taken branch that missed is allocated into the table. A hit that was taken strengthens its counter and refreshes its destination. A hit that was not taken first loses confidence and is removed on its second such outcome. The table is fully associative and holds only branches that have been taken.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss, a counter of 0, a target of 0 and a next address equal to the fetch address plus 4.
- R2: A lookup hits only when all 32 bits of the fetch address equal a stored branch address. An address that differs in any single bit, including bit 31 or bit 0, misses.
- R3: On a hit, the lookup reports the stored destination and counter, and it reports taken when counter bit 1 is set. When taken, the next fetch address is the stored destination. Otherwise it is the fetch address plus 4.
- R4: A valid resolve that misses and is taken writes a new entry: the branch address, the actual destination, and counter 2'b10 (weakly taken). The entry goes into the lowest-numbered empty slot.
- R5: When no slot is empty, allocation replaces the slot named by a replacement pointer. The pointer is 0 after reset and steps by one, wrapping at the table size, on each such replacement only.
- R6: A valid resolve that hits and is taken raises the counter by one, saturating at 2'b11, and overwrites the stored destination with the actual one.
- R7: A valid resolve that hits and is not taken lowers a 2'b11 counter to 2'b10 and keeps the entry. An entry at 2'b10 is deleted. A stored entry therefore never holds a counter below 2'b10.
- R8: A valid resolve that misses and is not taken leaves the table unchanged.
- R9: The mispredict flag is high in the same cycle when a valid resolve either has a direction different from the one used by fetch, or is taken with a destination different from the one used by fetch. The restart address is the actual destination when the branch is taken and the branch address plus 4 when it is not.
- R10: When a lookup and a resolve occur in the same cycle, the lookup sees the table as it was before that resolve. The write is visible from the next cycle on.
- R11: While no valid resolve is presented, the table and the replacement pointer do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_pc_i | input | 32 | Fetch address to look up |
| fe_hit_o | output | 1 | Fetch address matches a stored branch |
| fe_taken_o | output | 1 | Hit with counter predicting taken |
| fe_target_o | output | 32 | Stored destination on a hit, else 0 |
| fe_ctr_o | output | 2 | Stored counter on a hit, else 0 |
| fe_next_pc_o | output | 32 | Next fetch address |
| ex_valid_i | input | 1 | A resolved branch is presented |
| ex_pc_i | input | 32 | Address of the resolved branch |
| ex_taken_i | input | 1 | Actual direction |
| ex_target_i | input | 32 | Actual destination when taken |
| ex_pred_taken_i | input | 1 | Direction that fetch used |
| ex_pred_target_i | input | 32 | Destination that fetch used |
| ex_mispredict_o | output | 1 | Squash and refetch needed |
| ex_redirect_pc_o | output | 32 | Address at which to restart fetch |

## Verification
The bench targets addresses that are identical except for the top or bottom bit. A design that compared only part of the address would then hit falsely and steer fetch to a foreign target. It fills the table and allocates two more branches to check that the oldest slots go in order. A wrong replacement pointer would evict a live entry or overwrite the wrong slot. It sends a resolve for the address being looked up in the same cycle, which catches a design that bypasses the write into the lookup. It also drives two not-taken outcomes in a row to check the keep-then-delete step: a design that deleted at once or never deleted would disagree on the second lookup. A long constrained-random run with a small address pool adds mispredict and restart checks against a bench model.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int PC_W       = 32;
    localparam int CTR_W      = 2;
    localparam int INSN_BYTES = 4;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic             vld;
        pc_t              tag;
        pc_t              tgt;
        logic [CTR_W-1:0] ctr;
    } btb_ent_t;

    localparam logic [CTR_W-1:0] CTR_WEAK_T   = 2'b10;
    localparam logic [CTR_W-1:0] CTR_STRONG_T = 2'b11;
endpackage

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  btb_ent_t [N-1:0] ents_i,
    input  pc_t              pc_i,
    output logic             hit_o,
    output logic [IW-1:0]    idx_o,
    output logic [N-1:0]     vec_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec_o[g] = ents_i[g].vld && (ents_i[g].tag == pc_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_o[i]) idx_o = IW'(i);
        end
    end

    assign hit_o = |vec_o;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vld_i,
    input  logic [IW-1:0] rr_i,
    output logic [IW-1:0] slot_o,
    output logic          full_o
);
    logic found;

    always_comb begin
        full_o = &vld_i;
        slot_o = rr_i;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!vld_i[i] && !found) begin
                slot_o = IW'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [btb_pkg::PC_W-1:0] fe_pc_i,
    output logic                   fe_hit_o,
    output logic                   fe_taken_o,
    output logic [btb_pkg::PC_W-1:0] fe_target_o,
    output logic [btb_pkg::CTR_W-1:0] fe_ctr_o,
    output logic [btb_pkg::PC_W-1:0] fe_next_pc_o,
    input  logic                   ex_valid_i,
    input  logic [btb_pkg::PC_W-1:0] ex_pc_i,
    input  logic                   ex_taken_i,
    input  logic [btb_pkg::PC_W-1:0] ex_target_i,
    input  logic                   ex_pred_taken_i,
    input  logic [btb_pkg::PC_W-1:0] ex_pred_target_i,
    output logic                   ex_mispredict_o,
    output logic [btb_pkg::PC_W-1:0] ex_redirect_pc_o
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IW-1:0] RR_LAST = IW'(ENTRIES - 1);

    typedef struct packed {
        btb_ent_t [ENTRIES-1:0] ent;
        logic [IW-1:0]          rr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] vld_vec;
    logic [ENTRIES-1:0] fe_vec, ex_vec;
    logic               fe_hit, ex_hit, tbl_full;
    logic [IW-1:0]      fe_idx, ex_idx, alloc_slot;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = st_q.ent[g].vld;
    end

    btb_match #(.N(ENTRIES), .IW(IW)) u_fe_match (
        .ents_i (st_q.ent),
        .pc_i   (fe_pc_i),
        .hit_o  (fe_hit),
        .idx_o  (fe_idx),
        .vec_o  (fe_vec)
    );

    btb_match #(.N(ENTRIES), .IW(IW)) u_ex_match (
        .ents_i (st_q.ent),
        .pc_i   (ex_pc_i),
        .hit_o  (ex_hit),
        .idx_o  (ex_idx),
        .vec_o  (ex_vec)
    );

    btb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
        .vld_i  (vld_vec),
        .rr_i   (st_q.rr),
        .slot_o (alloc_slot),
        .full_o (tbl_full)
    );

    // Next-state: all table writes come from the resolve port.
    always_comb begin
        st_d = st_q;
        if (ex_valid_i) begin
            if (ex_hit) begin
                if (ex_taken_i) begin
                    st_d.ent[ex_idx].tgt = ex_target_i;
                    if (st_q.ent[ex_idx].ctr != CTR_STRONG_T)
                        st_d.ent[ex_idx].ctr = st_q.ent[ex_idx].ctr + 1'b1;
                end else if (st_q.ent[ex_idx].ctr == CTR_STRONG_T) begin
                    st_d.ent[ex_idx].ctr = CTR_WEAK_T;
                end else begin
                    st_d.ent[ex_idx].vld = 1'b0;
                end
            end else if (ex_taken_i) begin
                st_d.ent[alloc_slot] = '{vld: 1'b1, tag: ex_pc_i,
                                         tgt: ex_target_i, ctr: CTR_WEAK_T};
                if (tbl_full)
                    st_d.rr = (st_q.rr == RR_LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lookup path reads the registered table only.
    always_comb begin
        fe_hit_o     = fe_hit;
        fe_ctr_o     = fe_hit ? st_q.ent[fe_idx].ctr : '0;
        fe_target_o  = fe_hit ? st_q.ent[fe_idx].tgt : '0;
        fe_taken_o   = fe_hit && st_q.ent[fe_idx].ctr[CTR_W-1];
        fe_next_pc_o = fe_taken_o ? st_q.ent[fe_idx].tgt
                                  : fe_pc_i + PC_W'(INSN_BYTES);
    end

    always_comb begin
        ex_mispredict_o  = ex_valid_i &&
                           ((ex_taken_i != ex_pred_taken_i) ||
                            (ex_taken_i && (ex_pred_target_i != ex_target_i)));
        ex_redirect_pc_o = ex_taken_i ? ex_target_i : ex_pc_i + PC_W'(INSN_BYTES);
    end

    // Allocation only on a miss keeps each address in at most one slot.
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fe_vec) && $onehot0(ex_vec));

    p_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && !ex_hit && ex_taken_i) |=>
            (st_q.ent[$past(alloc_slot)].vld &&
             st_q.ent[$past(alloc_slot)].tag == $past(ex_pc_i) &&
             st_q.ent[$past(alloc_slot)].ctr == CTR_WEAK_T));

    p_rr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && !ex_hit && ex_taken_i && tbl_full) |=>
            (st_q.rr != $past(st_q.rr)));

    p_delete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && ex_hit && !ex_taken_i &&
         st_q.ent[ex_idx].ctr == CTR_WEAK_T) |=>
            !st_q.ent[$past(ex_idx)].vld);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_floor
        p_ctr_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[g].vld |-> st_q.ent[g].ctr[CTR_W-1]);
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid_i |=> $stable(st_q));
endmodule

// File: tb/sim_btb_top.sv
module sim_btb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fe_pc_i = '0;
    logic        fe_hit_o, fe_taken_o;
    logic [31:0] fe_target_o, fe_next_pc_o;
    logic [1:0]  fe_ctr_o;
    logic        ex_valid_i = 1'b0, ex_taken_i = 1'b0, ex_pred_taken_i = 1'b0;
    logic [31:0] ex_pc_i = '0, ex_target_i = '0, ex_pred_target_i = '0;
    logic        ex_mispredict_o;
    logic [31:0] ex_redirect_pc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // 20-unit period: 50 MHz with nanosecond units
    always #10 clk = ~clk;

    btb_top #(.ENTRIES(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fe_pc_i(fe_pc_i), .fe_hit_o(fe_hit_o), .fe_taken_o(fe_taken_o),
        .fe_target_o(fe_target_o), .fe_ctr_o(fe_ctr_o), .fe_next_pc_o(fe_next_pc_o),
        .ex_valid_i(ex_valid_i), .ex_pc_i(ex_pc_i), .ex_taken_i(ex_taken_i),
        .ex_target_i(ex_target_i), .ex_pred_taken_i(ex_pred_taken_i),
        .ex_pred_target_i(ex_pred_target_i), .ex_mispredict_o(ex_mispredict_o),
        .ex_redirect_pc_o(ex_redirect_pc_o)
    );

    // Reference model built from the requirements
    logic        m_vld [N];
    logic [31:0] m_tag [N];
    logic [31:0] m_tgt [N];
    logic [1:0]  m_ctr [N];
    int          m_rr;

    function automatic logic [31:0] pool(int k);
        if (k < 20) return 32'h0000_1000 + 32'(k) * 4;
        return 32'h8000_1000 + 32'(k - 20) * 4;
    endfunction

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
        end
        m_rr = 0;
    endtask

    task automatic m_update(logic rv, logic [31:0] rpc, logic rt, logic [31:0] rtgt);
        int k, s;
        if (!rv) return;
        k = m_find(rpc);
        if (k >= 0) begin
            if (rt) begin
                m_tgt[k] = rtgt;
                if (m_ctr[k] != 2'b11) m_ctr[k] = m_ctr[k] + 2'd1;
            end else if (m_ctr[k] == 2'b11) m_ctr[k] = 2'b10;
            else m_vld[k] = 1'b0;
        end else if (rt) begin
            s = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) s = i;
            if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
            m_vld[s] = 1'b1; m_tag[s] = rpc; m_tgt[s] = rtgt; m_ctr[s] = 2'b10;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ex_valid_i = 1'b0;
        m_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive away from the edge, check old-state outputs, advance model
    task automatic step(logic [31:0] lk, logic rv, logic [31:0] rpc, logic rt,
                        logic [31:0] rtgt, logic rpt, logic [31:0] rptgt, string req);
        int k;
        logic eh, et, emis;
        logic [31:0] etgt, enext, ered;
        logic [1:0] ectr;
        @(negedge clk);
        fe_pc_i = lk; ex_valid_i = rv; ex_pc_i = rpc; ex_taken_i = rt;
        ex_target_i = rtgt; ex_pred_taken_i = rpt; ex_pred_target_i = rptgt;
        #1;
        k = m_find(lk);
        eh = (k >= 0);
        et = eh && m_ctr[k][1];
        etgt = eh ? m_tgt[k] : 32'd0;
        ectr = eh ? m_ctr[k] : 2'd0;
        enext = et ? m_tgt[k] : lk + 32'd4;
        emis = rv && ((rt != rpt) || (rt && rptgt != rtgt));
        ered = rt ? rtgt : rpc + 32'd4;
        chk(req, "hit", 32'(fe_hit_o), 32'(eh));
        chk(req, "taken", 32'(fe_taken_o), 32'(et));
        chk(req, "target", fe_target_o, etgt);
        chk(req, "ctr", 32'(fe_ctr_o), 32'(ectr));
        chk(req, "next_pc", fe_next_pc_o, enext);
        chk("R9", "mispredict", 32'(ex_mispredict_o), 32'(emis));
        if (rv) chk("R9", "redirect", ex_redirect_pc_o, ered);
        m_update(rv, rpc, rt, rtgt);
    endtask

    task automatic look(logic [31:0] lk, string req);
        step(lk, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic resolve(logic [31:0] pc, logic t, logic [31:0] tgt, string req);
        step(pc, 1'b1, pc, t, tgt, 1'b0, pc + 32'd4, req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_clear();
        do_reset();

        // R1: empty after reset
        look(pool(0), "R1");
        look(pool(21), "R1");

        // R10: allocation seen only from the next cycle
        step(pool(3), 1'b1, pool(3), 1'b1, 32'h0000_4000, 1'b0, pool(3) + 32'd4, "R10");
        look(pool(3), "R10");
        // R4: weak-taken allocation, R3: steering to the stored target
        look(pool(3), "R4");
        look(pool(3), "R3");

        // R6: strengthen and refresh target; saturation
        resolve(pool(3), 1'b1, 32'h0000_5000, "R6");
        look(pool(3), "R6");
        resolve(pool(3), 1'b1, 32'h0000_6000, "R6");
        look(pool(3), "R6");

        // R7: keep at 11 -> 10, delete at 10
        resolve(pool(3), 1'b0, 32'h0, "R7");
        look(pool(3), "R7");
        resolve(pool(3), 1'b0, 32'h0, "R7");
        look(pool(3), "R7");

        // R8: untaken miss allocates nothing
        resolve(pool(5), 1'b0, 32'h0, "R8");
        look(pool(5), "R8");

        // R11: taken data without valid writes nothing
        step(pool(6), 1'b0, pool(6), 1'b1, 32'h0000_7000, 1'b1, 32'h0, "R11");
        look(pool(6), "R11");

        // R2: full-address compare
        resolve(pool(1), 1'b1, 32'h0000_8000, "R2");
        look(pool(1) ^ 32'h8000_0000, "R2");
        look(pool(1) ^ 32'h0000_0001, "R2");
        look(pool(1), "R2");

        // R5: fill, then replace in round-robin order
        do_reset();
        for (int k = 0; k < N; k++) resolve(pool(k), 1'b1, 32'h0001_0000 + 32'(k) * 16, "R5");
        resolve(pool(16), 1'b1, 32'h0002_0000, "R5");
        resolve(pool(17), 1'b1, 32'h0002_0010, "R5");
        look(pool(0), "R5");
        look(pool(1), "R5");
        look(pool(2), "R5");
        look(pool(16), "R5");
        look(pool(17), "R5");
        resolve(pool(2), 1'b0, 32'h0, "R5");
        resolve(pool(18), 1'b1, 32'h0002_0020, "R5");
        look(pool(18), "R5");
        look(pool(4), "R5");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] lk, rpc, rtgt, rptgt;
            logic rv, rt, rpt;
            int k;
            lk  = pool($urandom % 24);
            rv  = ($urandom % 4) != 0;
            rpc = pool($urandom % 24);
            rt  = ($urandom % 3) != 0;
            k   = m_find(rpc);
            rtgt = (k >= 0 && ($urandom % 2) == 1) ? m_tgt[k]
                                                   : ($urandom & 32'h000F_FFFC);
            if (($urandom % 4) != 0) begin
                rpt   = (k >= 0) && m_ctr[k][1];
                rptgt = (k >= 0) ? m_tgt[k] : rpc + 32'd4;
            end else begin
                rpt   = $urandom % 2;
                rptgt = $urandom & 32'h000F_FFFC;
            end
            step(lk, rv, rpc, rt, rtgt, rpt, rptgt, "R3");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule